// File: doc/BRIEF.md
# Effective Address Modification Unit

This block turns one 36-bit single-address instruction word into the operand location that the execution stage should use. It splits the word into its 18-bit address field and 7-bit tag. It then carries out the modification that the tag asks for. That can mean adding an index or half-accumulator value, following one or more indirect words through memory, or taking a tally field from an indirect word. The result is an 18-bit effective address, an immediate operand, or a fault.

The surrounding pipeline starts the block with a one-cycle `start_i` pulse while it is idle. Index and half-accumulator values come in through a select/data port that the block reads in the same cycle. The instruction counter comes in on its own input. Indirect words arrive through a request/valid read port. When the work is finished, the block raises `done_o` for one cycle and holds its result outputs until the next result is produced.

Top module: `ea_modifier`

## Requirements
- R1: Word bit 0 is the MSB, so bit k sits at `instr_i[35-k]`. The address field Y is `instr_i[35:18]`, the modifier is `instr_i[6:4]` and the designator is `instr_i[3:0]`. Modifier 000 with designator 13 yields effective address Y unchanged, with no memory read.
- R2: Modifier 000 with designator 0..11 yields Y plus the register value presented for that select code on `reg_sel_o`/`reg_data_i`. Designator 12 uses `ic_i` instead. The sum is taken modulo 2^18.
- R3: Modifier 000 with designator 14 or 15 sets `imm_o` and returns Y on `ea_o` with a zero tally and no fault.
- R4: Modifier 001 (register-then-indirect) first forms Y plus the register value, with designators 13..15 adding zero. It reads the word at that address and then processes the fetched word according to that word's own tag.
- R5: Modifier 010 (indirect-then-register) reads the word at Y and follows the chain of fetched tags. The first such word's designator is kept. When a fetched word with modifier 000 ends the chain, the kept designator is applied to that word's Y, and the final word's own designator is ignored.
- R6: Modifier 011 (indirect-then-tally) reads the word at Y. The fetched word's Y becomes the effective address, and its bits 30..35 (`[5:0]`) appear on `tally_o`. The fetched word's tag is not interpreted further.
- R7: Modifier values 100..111 raise `fault_o` with `fault_kind_o` = 0 and issue no memory read.
- R8: At most MAX_DEPTH (16) indirect reads are issued per instruction. A further read that would be needed instead raises `fault_o` with `fault_kind_o` = 1.
- R9: `start_i` is accepted only while `busy_o` is low. `done_o` lasts one cycle. `ea_o`, `imm_o`, `tally_o`, `fault_o` and `fault_kind_o` change only in the cycle `done_o` rises. After reset, all outputs are zero.
- R10: `mem_req_o` is raised only for the reads that R4..R6 call for. Once raised, it stays high with a stable `mem_addr_o` until `mem_valid_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken when idle |
| instr_i | input | 36 | Instruction word |
| ic_i | input | 18 | Instruction counter value |
| reg_sel_o | output | 4 | Designator of the register being read |
| reg_data_i | input | 18 | Value of the selected register |
| mem_req_o | output | 1 | Indirect word read request |
| mem_addr_o | output | 18 | Read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 36 | Fetched word |
| busy_o | output | 1 | Block is working on an instruction |
| done_o | output | 1 | Result valid, one cycle |
| ea_o | output | 18 | Effective address or immediate value |
| imm_o | output | 1 | Result is an immediate operand |
| tally_o | output | 6 | Tally from an indirect-then-tally word |
| fault_o | output | 1 | Modification fault |
| fault_kind_o | output | 1 | 0 = illegal modifier, 1 = depth cap |

## Verification
The bench sweeps every modifier and designator over several address fields. It uses a memory whose words themselves chain through every mode, including a self-referencing indirect word, and it varies the read latency. Several corner cases are targeted directly. A wrap past 2^18 would show up as a wrong high address. If the final designator came from the last word instead of the instruction, the indirect-then-register check would return the wrong sum. If the depth counter were off by one, the self-loop would report 15 or 17 reads or never stop. A start pulse that arrives while the block is busy would corrupt the pending result if it were not ignored.

// File: rtl/amu_pkg.sv
package amu_pkg;
    localparam int WORD_W = 36;
    localparam int ADDR_W = 18;
    localparam int TD_W   = 4;
    localparam int TM_W   = 3;
    localparam int TALLY_W = 6;

    localparam logic [TM_W-1:0] TM_REG  = 3'b000;
    localparam logic [TM_W-1:0] TM_RIND = 3'b001;
    localparam logic [TM_W-1:0] TM_INDR = 3'b010;
    localparam logic [TM_W-1:0] TM_TALLY = 3'b011;

    localparam logic [TD_W-1:0] TD_IC     = 4'd12;
    localparam logic [TD_W-1:0] TD_DIRECT = 4'd13;
    localparam int              NUM_GPR   = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } amu_state_e;
endpackage

// File: rtl/amu_word_split.sv
module amu_word_split
    import amu_pkg::*;
(
    input  logic [WORD_W-1:0]  word_i,
    output logic [ADDR_W-1:0]  y_o,
    output logic [TM_W-1:0]    tm_o,
    output logic [TD_W-1:0]    td_o,
    output logic [TALLY_W-1:0] tally_o
);
    // word bit k lives at vector index WORD_W-1-k
    assign y_o     = word_i[WORD_W-1 -: ADDR_W];
    assign tm_o    = word_i[TD_W +: TM_W];
    assign td_o    = word_i[TD_W-1:0];
    assign tally_o = word_i[TALLY_W-1:0];
endmodule

// File: rtl/amu_index_add.sv
module amu_index_add
    import amu_pkg::*;
(
    input  logic [ADDR_W-1:0] y_i,
    input  logic [TD_W-1:0]   td_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [ADDR_W-1:0] ic_i,
    output logic [ADDR_W-1:0] sum_o,
    output logic              imm_o
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        if (td_i < TD_W'(NUM_GPR)) begin
            offset = reg_i;
        end else if (td_i == TD_IC) begin
            offset = ic_i;
        end else begin
            offset = '0;
        end
    end

    // carry out of the top bit is dropped
    assign sum_o = y_i + offset;
    assign imm_o = (td_i > TD_DIRECT);
endmodule

// File: rtl/ea_modifier.sv
module ea_modifier
    import amu_pkg::*;
#(
    parameter int MAX_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [35:0]         instr_i,
    input  logic [17:0]         ic_i,
    output logic [3:0]          reg_sel_o,
    input  logic [17:0]         reg_data_i,
    output logic                mem_req_o,
    output logic [17:0]         mem_addr_o,
    input  logic                mem_valid_i,
    input  logic [35:0]         mem_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [17:0]         ea_o,
    output logic                imm_o,
    output logic [5:0]          tally_o,
    output logic                fault_o,
    output logic                fault_kind_o
);
    localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);

    typedef struct packed {
        amu_state_e           st;
        logic [WORD_W-1:0]    cur;
        logic                 pend;
        logic [TD_W-1:0]      ptd;
        logic [DEPTH_W-1:0]   depth;
        logic                 tally_rd;
        logic [ADDR_W-1:0]    addr;
        logic [ADDR_W-1:0]    ea;
        logic                 imm;
        logic [TALLY_W-1:0]   tally;
        logic                 fault;
        logic                 fkind;
    } amu_regs_t;

    amu_regs_t s_d, s_q;

    logic [ADDR_W-1:0]  cur_y;
    logic [TM_W-1:0]    cur_tm;
    logic [TD_W-1:0]    cur_td;
    logic [TALLY_W-1:0] cur_tally;
    logic [ADDR_W-1:0]  rd_y;
    logic [TM_W-1:0]    rd_tm;
    logic [TD_W-1:0]    rd_td;
    logic [TALLY_W-1:0] rd_tally;
    logic [TD_W-1:0]    eff_td;
    logic [ADDR_W-1:0]  idx_sum;
    logic               idx_imm;

    amu_word_split u_cur_split (
        .word_i  (s_q.cur),
        .y_o     (cur_y),
        .tm_o    (cur_tm),
        .td_o    (cur_td),
        .tally_o (cur_tally)
    );

    amu_word_split u_rd_split (
        .word_i  (mem_data_i),
        .y_o     (rd_y),
        .tm_o    (rd_tm),
        .td_o    (rd_td),
        .tally_o (rd_tally)
    );

    // a pending indirect-then-register designator replaces the final word's own
    always_comb begin
        if (cur_tm == TM_REG && s_q.pend) begin
            eff_td = s_q.ptd;
        end else begin
            eff_td = cur_td;
        end
    end

    amu_index_add u_add (
        .y_i   (cur_y),
        .td_i  (eff_td),
        .reg_i (reg_data_i),
        .ic_i  (ic_i),
        .sum_o (idx_sum),
        .imm_o (idx_imm)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st       = ST_EVAL;
                    s_d.cur      = instr_i;
                    s_d.pend     = 1'b0;
                    s_d.ptd      = '0;
                    s_d.depth    = '0;
                    s_d.tally_rd = 1'b0;
                end
            end
            ST_EVAL: begin
                if (cur_tm == TM_REG) begin
                    s_d.st    = ST_DONE;
                    s_d.ea    = idx_imm ? cur_y : idx_sum;
                    s_d.imm   = idx_imm;
                    s_d.tally = '0;
                    s_d.fault = 1'b0;
                    s_d.fkind = 1'b0;
                end else if (cur_tm == TM_RIND || cur_tm == TM_INDR ||
                             cur_tm == TM_TALLY) begin
                    if (s_q.depth == DEPTH_W'(MAX_DEPTH)) begin
                        s_d.st    = ST_DONE;
                        s_d.ea    = '0;
                        s_d.imm   = 1'b0;
                        s_d.tally = '0;
                        s_d.fault = 1'b1;
                        s_d.fkind = 1'b1;
                    end else begin
                        s_d.st       = ST_WAIT;
                        s_d.depth    = s_q.depth + 1'b1;
                        s_d.tally_rd = (cur_tm == TM_TALLY);
                        s_d.addr     = (cur_tm == TM_RIND) ? idx_sum : cur_y;
                        if (cur_tm == TM_INDR && !s_q.pend) begin
                            s_d.pend = 1'b1;
                            s_d.ptd  = cur_td;
                        end
                    end
                end else begin
                    s_d.st    = ST_DONE;
                    s_d.ea    = '0;
                    s_d.imm   = 1'b0;
                    s_d.tally = '0;
                    s_d.fault = 1'b1;
                    s_d.fkind = 1'b0;
                end
            end
            ST_WAIT: begin
                if (mem_valid_i) begin
                    if (s_q.tally_rd) begin
                        s_d.st    = ST_DONE;
                        s_d.ea    = rd_y;
                        s_d.imm   = 1'b0;
                        s_d.tally = rd_tally;
                        s_d.fault = 1'b0;
                        s_d.fkind = 1'b0;
                    end else begin
                        s_d.st  = ST_EVAL;
                        s_d.cur = mem_data_i;
                    end
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_sel_o    = eff_td;
    assign mem_req_o    = (s_q.st == ST_WAIT);
    assign mem_addr_o   = s_q.addr;
    assign busy_o       = (s_q.st != ST_IDLE);
    assign done_o       = (s_q.st == ST_DONE);
    assign ea_o         = s_q.ea;
    assign imm_o        = s_q.imm;
    assign tally_o      = s_q.tally;
    assign fault_o      = s_q.fault;
    assign fault_kind_o = s_q.fkind;

    // rd_tm and rd_td are consumed once the fetched word becomes current
    logic unused_rd;
    assign unused_rd = ^{rd_tm, rd_td, cur_tally};
endmodule

// File: rtl/ea_modifier_chk.sv
module ea_modifier_chk #(
    parameter int MAX_DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        mem_req_o,
    input logic [17:0] mem_addr_o,
    input logic        mem_valid_i,
    input logic [17:0] ea_o,
    input logic        imm_o,
    input logic [5:0]  tally_o,
    input logic        fault_o,
    input logic        fault_kind_o
);
    int rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 0;
        end else if (start_i && !busy_o) begin
            rd_cnt <= 0;
        end else if (mem_req_o && mem_valid_i) begin
            rd_cnt <= rd_cnt + 1;
        end
    end

    AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= MAX_DEPTH); // R8

    AST_IMM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && imm_o |-> !fault_o && tally_o == 6'd0); // R3

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ea_o) && $stable(imm_o) && $stable(tally_o) &&
                    $stable(fault_o) && $stable(fault_kind_o)); // R9
endmodule

bind ea_modifier ea_modifier_chk #(.MAX_DEPTH(MAX_DEPTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_valid_i  (mem_valid_i),
    .ea_o         (ea_o),
    .imm_o        (imm_o),
    .tally_o      (tally_o),
    .fault_o      (fault_o),
    .fault_kind_o (fault_kind_o)
);

// File: tb/ea_modifier_tb_top.sv
module ea_modifier_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [35:0] instr_i;
    logic [17:0] ic_i;
    logic [3:0]  reg_sel_o;
    logic [17:0] reg_data_i;
    logic        mem_req_o;
    logic [17:0] mem_addr_o;
    logic        mem_valid_i;
    logic [35:0] mem_data_i;
    logic        busy_o, done_o, imm_o, fault_o, fault_kind_o;
    logic [17:0] ea_o;
    logic [5:0]  tally_o;

    logic [35:0] mem [64];
    logic [17:0] regs [16];
    int lat = 0;
    int wcnt = 0;
    int nf = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ea_modifier #(.MAX_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .ic_i(ic_i), .reg_sel_o(reg_sel_o), .reg_data_i(reg_data_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i),
        .busy_o(busy_o), .done_o(done_o), .ea_o(ea_o), .imm_o(imm_o),
        .tally_o(tally_o), .fault_o(fault_o), .fault_kind_o(fault_kind_o)
    );

    assign reg_data_i  = regs[reg_sel_o];
    assign mem_valid_i = mem_req_o && (wcnt >= lat);
    assign mem_data_i  = mem[mem_addr_o[5:0]];

    always @(posedge clk) begin
        if (mem_req_o && !mem_valid_i) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_req_o && mem_valid_i) nf <= nf + 1;
    end

    function automatic logic [35:0] mk(input logic [17:0] y, input logic [2:0] tm,
                                       input logic [3:0] td);
        return {y, 9'h0, 1'b0, 1'b0, tm, td};
    endfunction

    function automatic logic [17:0] regval(input logic [3:0] td);
        if (td < 4'd12) return regs[td];
        if (td == 4'd12) return ic_i;
        return 18'h0;
    endfunction

    function automatic void ref_model(input logic [35:0] w, output logic [17:0] ea,
                                      output logic imm, output logic [5:0] tl,
                                      output logic flt, output logic fk,
                                      output int nfe);
        logic [35:0] cur;
        logic        pend;
        logic [3:0]  ptd, use_td;
        logic [17:0] y;
        logic [2:0]  tm;
        bit          fin;
        cur = w; pend = 0; ptd = 0; fin = 0;
        ea = 0; imm = 0; tl = 0; flt = 0; fk = 0; nfe = 0;
        for (int g = 0; g < 64 && !fin; g++) begin
            y = cur[35:18]; tm = cur[6:4];
            if (tm == 3'd0) begin
                use_td = pend ? ptd : cur[3:0];
                if (use_td >= 4'd14) begin imm = 1; ea = y; end
                else ea = y + regval(use_td);
                fin = 1;
            end else if (tm <= 3'd3) begin
                if (nfe == DEPTH) begin
                    flt = 1; fk = 1; fin = 1;
                end else begin
                    nfe++;
                    if (tm == 3'd1) begin
                        cur = mem[5'(0) + 6'(y + regval(cur[3:0]))];
                    end else if (tm == 3'd2) begin
                        if (!pend) begin pend = 1; ptd = cur[3:0]; end
                        cur = mem[y[5:0]];
                    end else begin
                        ea = mem[y[5:0]][35:18];
                        tl = mem[y[5:0]][5:0];
                        fin = 1;
                    end
                end
            end else begin
                flt = 1; fk = 0; fin = 1;
            end
        end
    endfunction

    task automatic check(input bit ok, input string rtag, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", rtag, msg);
        end
    endtask

    task automatic run_op(input logic [35:0] w, input string rtag);
        logic [17:0] e_ea; logic e_imm; logic [5:0] e_tl; logic e_f, e_fk; int e_n;
        int nf0, cyc;
        ref_model(w, e_ea, e_imm, e_tl, e_f, e_fk, e_n);
        @(negedge clk);
        instr_i = w; start_i = 1'b1; nf0 = nf;
        @(negedge clk);
        start_i = 1'b0; cyc = 0;
        while (!done_o && cyc < 400) begin
            @(negedge clk); cyc++;
        end
        check(done_o && ea_o == e_ea && imm_o == e_imm && tally_o == e_tl &&
              fault_o == e_f && (!e_f || fault_kind_o == e_fk) && (nf - nf0) == e_n,
              rtag,
              $sformatf("w=%h actual ea=%h imm=%0b tl=%h f=%0b k=%0b rd=%0d expected ea=%h imm=%0b tl=%h f=%0b k=%0b rd=%0d",
                        w, ea_o, imm_o, tally_o, fault_o, fault_kind_o, nf - nf0,
                        e_ea, e_imm, e_tl, e_f, e_fk, e_n));
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        string tags [8];
        logic [17:0] ys [4];
        logic [17:0] hold_ea;
        tags = '{"R2", "R4", "R5", "R6", "R7", "R7", "R7", "R7"};
        ys = '{18'h00000, 18'h00005, 18'h3FFFE, 18'h20025};
        rst_n = 1'b0; start_i = 1'b0; instr_i = '0; ic_i = 18'h2A5F0;
        for (int k = 0; k < 16; k++) regs[k] = 18'(k * 18'h01111 + 18'h00007);
        regs[3] = 18'h3FFFF;
        regs[1] = 18'h00010;
        for (int i = 0; i < 64; i++) begin
            mem[i] = {18'(((i * 13 + 5) % 64)) | ((i % 2) != 0 ? 18'h3FFC0 : 18'h0),
                      9'(i), 2'b00, 3'((i * 5) % 4), 4'((i * 7) % 16)};
        end
        mem[63] = mk(18'h00011, 3'd6, 4'd2);
        mem[40] = mk(18'd40, 3'd2, 4'd0);
        mem[48] = mk(18'h0ABCD, 3'd0, 4'd13);
        mem[50] = mk(18'd51, 3'd2, 4'd9);
        mem[51] = mk(18'h00100, 3'd0, 4'd5);
        mem[20] = {18'h01234, 9'h1A5, 2'b00, 7'b1011011};
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !mem_req_o && ea_o == 0 && !fault_o && tally_o == 0,
              "R9", $sformatf("reset state busy=%0b done=%0b ea=%h expected all zero",
                              busy_o, done_o, ea_o));
        rst_n = 1'b1;

        run_op(mk(18'h12345, 3'd0, 4'd13), "R1");
        run_op(mk(18'h00002, 3'd0, 4'd3), "R2");
        check(ea_o == 18'h00001, "R2", $sformatf("wrap actual %h expected 00001", ea_o));
        run_op(mk(18'h3F000, 3'd0, 4'd12), "R2");
        check(ea_o == 18'h3F000 + 18'h2A5F0, "R2",
              $sformatf("ic add actual %h expected %h", ea_o, 18'h3F000 + 18'h2A5F0));
        run_op(mk(18'h0BEEF, 3'd0, 4'd14), "R3");
        check(imm_o && ea_o == 18'h0BEEF, "R3",
              $sformatf("imm actual %0b/%h expected 1/0beef", imm_o, ea_o));
        run_op(mk(18'h00020, 3'd1, 4'd1), "R4");
        check(ea_o == 18'h0ABCD, "R4", $sformatf("actual %h expected 0abcd", ea_o));
        run_op(mk(18'd50, 3'd2, 4'd2), "R5");
        check(ea_o == 18'h00100 + regs[2], "R5",
              $sformatf("actual %h expected %h", ea_o, 18'h00100 + regs[2]));
        lat = 3;
        run_op(mk(18'd20, 3'd3, 4'd0), "R6");
        check(ea_o == 18'h01234 && tally_o == 6'b011011, "R6",
              $sformatf("actual %h/%h expected 01234/1b", ea_o, tally_o));
        lat = 0;
        run_op(mk(18'h00001, 3'd5, 4'd0), "R7");
        check(fault_o && !fault_kind_o, "R7",
              $sformatf("actual f=%0b k=%0b expected 1/0", fault_o, fault_kind_o));
        run_op(mk(18'd40, 3'd2, 4'd0), "R8");
        check(fault_o && fault_kind_o, "R8",
              $sformatf("actual f=%0b k=%0b expected 1/1", fault_o, fault_kind_o));

        // R9: a start pulse during a busy period is ignored; result stays put afterwards
        lat = 5;
        @(negedge clk);
        instr_i = mk(18'd20, 3'd3, 4'd0); start_i = 1'b1;
        @(negedge clk);
        instr_i = mk(18'h00777, 3'd0, 4'd13);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 50 && !done_o; c++) @(negedge clk);
        check(done_o && ea_o == 18'h01234, "R9",
              $sformatf("busy start actual %h expected 01234", ea_o));
        hold_ea = ea_o;
        repeat (3) @(negedge clk);
        check(!done_o && !busy_o && ea_o == hold_ea, "R9",
              $sformatf("hold actual %h expected %h", ea_o, hold_ea));
        lat = 0;

        // sweep every modifier and designator
        for (int tm = 0; tm < 8; tm++) begin
            for (int td = 0; td < 16; td++) begin
                for (int yi = 0; yi < 4; yi++) begin
                    lat = (tm + td + yi) % 3;
                    run_op(mk(ys[yi], 3'(tm), 4'(td)),
                           (tm == 0 && td == 13) ? "R1" :
                           (tm == 0 && td >= 14) ? "R3" : tags[tm]);
                end
            end
        end
        for (int i = 0; i < 64; i++) begin
            lat = i % 2;
            run_op(mk(18'(i), 3'd2, 4'(i % 16)), "R8");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule